// File: doc/BRIEF.md
# ASCII Two-Digit Decimal to Signed Byte Converter

This block turns a pair of ASCII decimal digit characters, one for tens and one for units, into the signed two's complement byte they denote. A third character slot can carry an optional leading minus sign. The block has no clock and no state, so the output is a pure function of the three characters presented at the moment.

The numeric weight of each digit comes straight from its low four bits, with no subtraction of the character offset. Multiplying the tens digit by ten needs no multiplier: the sum is built as units + (tens shifted left by one) + (tens shifted left by three). Two chained adders do this. The first is 6 bits wide and the second 7 bits wide, and a zero is then placed in front of the 7-bit result. When the sign slot holds a minus, XOR inverters plus a +1 carry turn that magnitude into its negative. Any malformed character raises an invalid flag and forces the output to zero.

Top module: `ascii_dec2_to_s8`

## Requirements
- R1: With a valid input and the sign slot unused (0x20 space or 0x00 null), `value` equals 10 × (tens_char[3:0]) + (units_char[3:0]).
- R2: With a valid input and the sign slot unused, bit 7 of `value` is 0.
- R3: With a valid input and sign_char equal to 0x2D (ASCII minus), `value` is the 8-bit two's complement negation of 10 × tens + units.
- R4: The input "-00" (minus, then 0x30, then 0x30) gives `value` = 0x00.
- R5: `bad` is 1 whenever tens_char or units_char lies outside 0x30..0x39. This includes codes with bit 7 set, such as 0xB5.
- R6: `bad` is 1 whenever sign_char is not one of 0x2D, 0x20 or 0x00. With all three characters well formed, `bad` is 0.
- R7: Whenever `bad` is 1, `value` is 0x00.
- R8: `value` and `bad` follow their inputs with no clock and no stored state. A new input pattern shows at the outputs without any clock edge.
- R9: `value`, read as signed, always lies in -99..+99.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sign_char | input | 8 | Optional sign character: 0x2D negates; 0x20 or 0x00 means no sign |
| tens_char | input | 8 | ASCII tens digit, 0x30..0x39 |
| units_char | input | 8 | ASCII units digit, 0x30..0x39 |
| value | output | 8 | Signed two's complement result, zero when the input is invalid |
| bad | output | 1 | High when any character is malformed |

## Verification
The embedded checks assume the three character buses have settled before they are read. They also assume the arithmetic check applies only when `bad` is low, because malformed nibbles such as 0x3F would otherwise fall outside the decimal meaning. To stay inside this, the stimulus holds each character pattern for a full time step before sampling. It sweeps all 100 legal digit pairs under each of the three legal sign states. Malformed cases are applied separately: near misses around 0x30/0x39, a high-bit digit and stray sign characters. For those cases only the flag and the forced zero are observed.

// File: rtl/ascii_dec2_to_s8.sv
module ascii_dec2_to_s8 #(
  parameter logic [7:0] MINUS_CODE = 8'h2D,
  parameter logic [7:0] BLANK_CODE = 8'h20,
  parameter logic [7:0] NULL_CODE  = 8'h00,
  parameter logic [7:0] DIGIT_LO   = 8'h30,
  parameter logic [7:0] DIGIT_HI   = 8'h39
) (
  input  logic [7:0] sign_char,
  input  logic [7:0] tens_char,
  input  logic [7:0] units_char,
  output logic [7:0] value,
  output logic       bad
);

  logic [3:0] t_nib, u_nib;
  logic [5:0] partial;
  logic [6:0] mag7;
  logic [7:0] mag8, signed_res;
  logic       neg, tens_ok, units_ok, sign_ok;

  assign t_nib = tens_char[3:0];
  assign u_nib = units_char[3:0];

  assign tens_ok  = (tens_char  >= DIGIT_LO) && (tens_char  <= DIGIT_HI);
  assign units_ok = (units_char >= DIGIT_LO) && (units_char <= DIGIT_HI);
  assign neg      = (sign_char == MINUS_CODE);
  assign sign_ok  = neg || (sign_char == BLANK_CODE) || (sign_char == NULL_CODE);
  assign bad      = !(tens_ok && units_ok && sign_ok);

  assign partial = {1'b0, t_nib, 1'b0} + {2'b00, u_nib};
  assign mag7    = {t_nib, 3'b000} + {1'b0, partial};
  assign mag8    = {1'b0, mag7};

  assign signed_res = (mag8 ^ {8{neg}}) + {7'd0, neg};
  assign value      = bad ? 8'h00 : signed_res;

  logic [7:0] chk_pos;
  always_comb begin
    chk_pos = 8'(t_nib) * 8'd10 + 8'(u_nib);
    if (!bad && !neg) begin
      p_pos_value_r1: assert (value == chk_pos)
        else $error("p_pos_value_r1 value=%h exp=%h", value, chk_pos);
      p_pos_msb_r2: assert (value[7] == 1'b0)
        else $error("p_pos_msb_r2 value=%h", value);
    end
    if (!bad && neg) begin
      p_neg_value_r3: assert (value == 8'd0 - chk_pos)
        else $error("p_neg_value_r3 value=%h", value);
    end
    if (!bad && t_nib == 4'd0 && u_nib == 4'd0) begin
      p_zero_r4: assert (value == 8'h00)
        else $error("p_zero_r4 value=%h", value);
    end
    if (bad) begin
      p_bad_zero_r7: assert (value == 8'h00)
        else $error("p_bad_zero_r7 value=%h", value);
    end
    p_range_r9: assert ($signed(value) >= -8'sd99 && $signed(value) <= 8'sd99)
      else $error("p_range_r9 value=%h", value);
  end

endmodule

// File: tb/tb_ascii_dec2_to_s8.sv
module tb_ascii_dec2_to_s8;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0] sign_char, tens_char, units_char, value;
  logic       bad;
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  ascii_dec2_to_s8 dut (.sign_char(sign_char), .tens_char(tens_char),
                        .units_char(units_char), .value(value), .bad(bad));

  task automatic apply(input logic [7:0] s, input logic [7:0] t, input logic [7:0] u);
    sign_char = s; tens_char = t; units_char = u;
    #1;
  endtask

  task automatic expect_out(input string req, input logic [7:0] ev, input logic eb);
    n_vec++;
    if (value !== ev || bad !== eb) begin
      n_bad++;
      $display("FAIL %s in=%h/%h/%h value=%h bad=%b expected value=%h bad=%b",
               req, sign_char, tens_char, units_char, value, bad, ev, eb);
    end
  endtask

  task automatic t_unsigned_sweep;
    for (int t = 0; t < 10; t++)
      for (int u = 0; u < 10; u++) begin
        apply(8'h20, 8'(8'h30 + t), 8'(8'h30 + u));
        expect_out("R1/R2 blank sign", 8'(10 * t + u), 1'b0);
        apply(8'h00, 8'(8'h30 + t), 8'(8'h30 + u));
        expect_out("R1/R2 null sign", 8'(10 * t + u), 1'b0);
      end
  endtask

  task automatic t_negative_sweep;
    for (int t = 0; t < 10; t++)
      for (int u = 0; u < 10; u++) begin
        apply(8'h2D, 8'(8'h30 + t), 8'(8'h30 + u));
        expect_out("R3/R9 minus", 8'(0 - (10 * t + u)), 1'b0);
      end
  endtask

  task automatic t_corners;
    apply(8'h2D, 8'h30, 8'h30); expect_out("R4 minus zero", 8'h00, 1'b0);
    apply(8'h2D, 8'h39, 8'h39); expect_out("R9 low end -99", 8'h9D, 1'b0);
    apply(8'h20, 8'h39, 8'h39); expect_out("R9 high end 99", 8'h63, 1'b0);
  endtask

  task automatic t_bad_digits;
    apply(8'h20, 8'h2F, 8'h35); expect_out("R5 tens below range", 8'h00, 1'b1);
    apply(8'h20, 8'h3A, 8'h35); expect_out("R5 tens above range", 8'h00, 1'b1);
    apply(8'h2D, 8'h35, 8'h3F); expect_out("R5 units 0x3F", 8'h00, 1'b1);
    apply(8'h20, 8'h35, 8'hB5); expect_out("R5 units high bit", 8'h00, 1'b1);
    apply(8'h00, 8'h41, 8'h30); expect_out("R5 letter tens", 8'h00, 1'b1);
  endtask

  task automatic t_bad_sign;
    apply(8'h2B, 8'h34, 8'h32); expect_out("R6 plus sign", 8'h00, 1'b1);
    apply(8'h2C, 8'h34, 8'h32); expect_out("R6 comma sign", 8'h00, 1'b1);
    apply(8'hAD, 8'h34, 8'h32); expect_out("R6 minus with high bit", 8'h00, 1'b1);
    apply(8'h30, 8'h34, 8'h32); expect_out("R7 digit in sign slot", 8'h00, 1'b1);
  endtask

  task automatic t_comb_follow;
    apply(8'h20, 8'h31, 8'h32); expect_out("R8 first", 8'd12, 1'b0);
    sign_char = 8'h2D; #0.5;
    expect_out("R8 no edge needed", 8'hF4, 1'b0);
    units_char = 8'h37; #0.5;
    expect_out("R8 units change", 8'hEF, 1'b0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    apply(8'h20, 8'h30, 8'h30);
    expect_out("R1 initial zero", 8'h00, 1'b0);
    t_unsigned_sweep();
    t_negative_sweep();
    t_corners();
    t_bad_digits();
    t_bad_sign();
    t_comb_follow();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule